// File: doc/BRIEF.md
# RMII Receive Dibit-to-Byte Decoder

This block sits on the MAC side of a reduced media-independent interface. It samples the combined carrier/data-valid line, the two receive data bits and the receive error line on the 50 MHz reference clock. From these it recovers two separate signals: carrier sense and receive data valid. It waits for a preamble of `01` dibits and the `11` start dibit, then packs the following dibits into bytes. Each byte is presented with a one-cycle valid strobe, plus start-of-frame, end-of-frame and error flags.

At 100 Mb/s every clock cycle carries one dibit. At 10 Mb/s each dibit is held for `OVERSAMPLE` cycles and is taken once, from the middle cycle of its window. At the tail of a frame the line may fall on the first dibit of a nibble and rise again on the second. The decoder reads that pattern as carrier lost while data is still arriving. Carrier sense drops, and bytes keep coming until the line stays low across a nibble's second dibit.

Top module: `rmii_rx_decoder`

## Requirements
- R1: With `speed_10` low, one dibit is taken on every clock. With `speed_10` high, a counter restarts on the first cycle `crs_dv` is high after idle. One dibit is taken when the counter is at `OVERSAMPLE/2` of each `OVERSAMPLE`-cycle window, and the outputs change only on such cycles.
- R2: Before a frame, dibits `00` with `crs_dv` high are ignored. One or more `01` dibits followed by `11` start a frame, and `rx_dv` is high from the next cycle.
- R3: After the start dibit, dibits are packed four per byte, least significant first: the first dibit lands in `rx_data[1:0]`.
- R4: Each byte appears for one cycle with `rx_valid` high. `rx_sof` is high only with the first byte of a frame.
- R5: Inside a frame, dibit positions count 0 to 3 within each byte, and even positions start a nibble. `crs_dv` low on an even position and high on the next odd position keeps both dibits as data. `crs_dv` low on an odd position ends the frame.
- R6: `rx_eof` comes with the last complete byte of a frame. If one to three dibits of a further byte arrived, that last byte also carries `rx_err`. A frame with no complete byte produces no output.
- R7: `rx_err` is high on a byte if `rx_er` was high on any of its four dibit samples.
- R8: A dibit other than `00` or `01` before the start dibit, or a `00` or `10` after preamble has begun, is a false carrier. It produces no bytes, and `rx_dv` stays low until `crs_dv` has been low on two consecutive dibit samples.
- R9: Outside a frame, `crs` follows `crs_dv` at each dibit sample. Inside a frame, `crs` falls at the first low sample and stays low while `rx_dv` stays high until the frame ends.
- R10: While `rst_n` is low and just after it, `crs`, `rx_dv`, `rx_valid`, `rx_sof`, `rx_eof` and `rx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_10 | input | 1 | 1 selects 10 Mb/s oversampled mode |
| crs_dv | input | 1 | Combined carrier / data-valid line from the PHY |
| rxd | input | 2 | Receive dibit |
| rx_er | input | 1 | Receive error from the PHY |
| crs | output | 1 | Recovered carrier sense |
| rx_dv | output | 1 | Recovered receive data valid |
| rx_data | output | 8 | Assembled byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_sof | output | 1 | First byte of a frame |
| rx_eof | output | 1 | Last complete byte of a frame |
| rx_err | output | 1 | Byte carried a receive error or the frame ended mid-byte |

## Verification
The bench builds the decoder with `OVERSAMPLE` at its default of 10 and runs frames at both speeds from one table. In 10 Mb/s frames the bench drives the inverted dibit on the two outer cycles at each end of every window. This shows whether the sample falls mid-window. The table pairs tail-toggle frames with frames whose last byte is cut off after one to three dibits. This covers both readings of a low first dibit: more data still coming, or the frame over.

// File: rtl/rmii_rx_decoder.sv
module rmii_rx_decoder #(
  parameter int OVERSAMPLE = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_10,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  input  logic       rx_er,
  output logic       crs,
  output logic       rx_dv,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_sof,
  output logic       rx_eof,
  output logic       rx_err
);

  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA, S_SKIP} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       idx;
  logic [5:0]       sh;
  logic             acc_err, prev_crs, first;
  logic [7:0]       hold_data;
  logic             hold_ok, hold_sof, hold_err;

  wire       stb     = speed_10 ? (cnt == MID) : 1'b1;
  wire       end_now = (st == S_DATA) && !crs_dv && idx[0];
  wire       partial = idx[1] | prev_crs;
  wire [7:0] new_b   = {rxd, sh};
  wire       err_now = acc_err | rx_er;

  assign rx_dv = (st == S_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      acc_err <= 1'b0; prev_crs <= 1'b0; first <= 1'b0;
      hold_data <= '0; hold_ok <= 1'b0; hold_sof <= 1'b0; hold_err <= 1'b0;
      crs <= 1'b0; rx_data <= '0;
      rx_valid <= 1'b0; rx_sof <= 1'b0; rx_eof <= 1'b0; rx_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0; rx_sof <= 1'b0; rx_eof <= 1'b0; rx_err <= 1'b0;
      if (st == S_IDLE && !crs_dv) cnt <= '0;
      else cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (stb) begin
        prev_crs <= crs_dv;
        case (st)
          S_IDLE: begin
            crs <= crs_dv;
            if (crs_dv && rxd == 2'b01) st <= S_PRE;
            else if (crs_dv && rxd[1]) st <= S_SKIP;
          end
          S_PRE: begin
            crs <= crs_dv;
            if (!crs_dv) st <= S_IDLE;
            else if (rxd == 2'b11) begin
              st <= S_DATA; idx <= '0; acc_err <= 1'b0;
              first <= 1'b1; hold_ok <= 1'b0;
            end else if (rxd != 2'b01) st <= S_SKIP;
          end
          S_SKIP: begin
            crs <= crs_dv;
            if (!crs_dv && !prev_crs) st <= S_IDLE;
          end
          S_DATA: begin
            crs <= crs & crs_dv;
            if (end_now) begin
              st <= S_IDLE;
              if (hold_ok) begin
                rx_valid <= 1'b1; rx_data <= hold_data; rx_sof <= hold_sof;
                rx_eof <= 1'b1; rx_err <= hold_err | partial;
              end
              hold_ok <= 1'b0;
            end else begin
              sh  <= {rxd, sh[5:2]};
              idx <= idx + 1'b1;
              acc_err <= (idx == 2'd3) ? 1'b0 : err_now;
              if (idx == 2'd3) begin
                if (hold_ok) begin
                  rx_valid <= 1'b1; rx_data <= hold_data;
                  rx_sof <= hold_sof; rx_err <= hold_err;
                end
                hold_data <= new_b; hold_sof <= first; hold_err <= err_now;
                hold_ok <= 1'b1; first <= 1'b0;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    speed_10 && cnt != MID |=> $stable(rx_dv) && $stable(crs));
  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_sof_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof |-> rx_valid && !$past(rx_dv) == 1'b0);
  p_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eof |-> rx_valid && !rx_dv);
  p_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_eof |-> rx_dv);
  p_no_out_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_dv && !$past(rx_dv) |-> !rx_valid);
  p_dv_crs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> crs);
  p_crs_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dv && !crs |=> !crs);

endmodule

// File: tb/rmii_rx_decoder_tb.sv
module rmii_rx_decoder_tb;
  logic clk = 1'b0, rst_n = 1'b0, speed_10 = 1'b0, crs_dv = 1'b0, rx_er = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic crs, rx_dv, rx_valid, rx_sof, rx_eof, rx_err;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, per = 1;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rmii_rx_decoder #(.OVERSAMPLE(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .speed_10(speed_10), .crs_dv(crs_dv), .rxd(rxd),
    .rx_er(rx_er), .crs(crs), .rx_dv(rx_dv), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err));

  logic [7:0] cap_d [0:63];
  logic [2:0] cap_f [0:63];
  int cap_n = 0, tail_cyc = 0, dv_cnt = 0;

  always @(negedge clk) begin
    if (rx_valid) begin
      cap_d[cap_n % 64] <= rx_data;
      cap_f[cap_n % 64] <= {rx_sof, rx_eof, rx_err};
      cap_n <= cap_n + 1;
    end
    if (rx_dv && !crs) tail_cyc <= tail_cyc + 1;
    if (rx_dv) dv_cnt <= dv_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [1:0] d, input logic e);
    for (int k = 0; k < per; k++) begin
      crs_dv = c; rx_er = e;
      rxd = (per > 1 && (k < 2 || k >= per - 2)) ? ~d : d;
      @(negedge clk);
    end
  endtask

  task automatic idle_gap();
    for (int k = 0; k < 4; k++) drive(1'b0, 2'b00, 1'b0);
  endtask

  task automatic send_frame(input bit sp, input int nb, input int tail, input bit tog,
                            input int erb, input logic [7:0] fb);
    int n, ts, base, tb0, dv0, b;
    logic [7:0] v;
    logic c;
    bit e_err;
    n = 4 * nb + tail;
    ts = (n >= 4) ? ((n - 4) & ~1) : 0;
    speed_10 = sp; per = sp ? 10 : 1;
    @(negedge clk);
    base = cap_n; tb0 = tail_cyc; dv0 = dv_cnt;
    drive(1'b1, 2'b00, 1'b0); drive(1'b1, 2'b00, 1'b0);
    for (int k = 0; k < 7; k++) drive(1'b1, 2'b01, 1'b0);
    drive(1'b1, 2'b11, 1'b0);
    for (int j = 0; j < n; j++) begin
      b = j / 4;
      v = (b < nb) ? fb + 8'(b * 53) : 8'hC3;
      c = (tog && j >= ts) ? j[0] : 1'b1;
      drive(c, v[2 * (j % 4) +: 2], (erb == b + 1));
    end
    idle_gap();
    check(cap_n - base == nb, "R4 byte count", cap_n - base, nb);
    check((dv_cnt > dv0) == (nb > 0 || tail > 0), "R2 rx_dv seen",
          int'(dv_cnt > dv0), int'(nb > 0 || tail > 0));
    for (int i = 0; i < nb; i++) begin
      v = fb + 8'(i * 53);
      check(cap_d[(base + i) % 64] == v, "R3 byte value", cap_d[(base + i) % 64], v);
      check(cap_f[(base + i) % 64][2] == (i == 0), "R4 sof", cap_f[(base + i) % 64][2], (i == 0));
      check(cap_f[(base + i) % 64][1] == (i == nb - 1), "R6 eof", cap_f[(base + i) % 64][1], (i == nb - 1));
      e_err = (erb == i + 1) || (i == nb - 1 && tail != 0);
      check(cap_f[(base + i) % 64][0] == e_err, "R7/R6 err", cap_f[(base + i) % 64][0], e_err);
    end
    if (nb > 0) begin
      if (tog) check(tail_cyc - tb0 >= 4 * per, "R5 R9 toggle tail keeps rx_dv", tail_cyc - tb0, 4 * per);
      else check(tail_cyc - tb0 <= per, "R9 plain tail", tail_cyc - tb0, per);
    end
  endtask

  // {speed10, nb[1:0], tail[1:0], toggle, er_byte[1:0], first_byte[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 2'd2, 2'd0, 1'b0, 2'd0, 8'hD5},
    {1'b0, 2'd3, 2'd0, 1'b1, 2'd0, 8'h3C},
    {1'b0, 2'd1, 2'd2, 1'b0, 2'd0, 8'h81},
    {1'b0, 2'd2, 2'd1, 1'b0, 2'd1, 8'h5A},
    {1'b0, 2'd2, 2'd2, 1'b1, 2'd0, 8'hF0},
    {1'b1, 2'd2, 2'd0, 1'b0, 2'd2, 8'h47},
    {1'b1, 2'd1, 2'd0, 1'b1, 2'd0, 8'h96},
    {1'b1, 2'd3, 2'd3, 1'b0, 2'd0, 8'h0F}
  };

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    finish_up();
  end

  initial begin
    int c0, d0;
    repeat (3) @(negedge clk);
    check({crs, rx_dv, rx_valid, rx_sof, rx_eof, rx_err} == 6'b0, "R10 in reset",
          {crs, rx_dv, rx_valid, rx_sof, rx_eof, rx_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({crs, rx_dv, rx_valid} == 3'b0, "R10 after reset", {crs, rx_dv, rx_valid}, 0);

    for (int t = 0; t < 8; t++)
      send_frame(VEC[t][15], int'(VEC[t][14:13]), int'(VEC[t][12:11]), VEC[t][10],
                 int'(VEC[t][9:8]), VEC[t][7:0]);

    speed_10 = 1'b0; per = 1;
    c0 = cap_n; d0 = dv_cnt;
    drive(1'b1, 2'b00, 1'b0); drive(1'b1, 2'b00, 1'b0);
    check(crs == 1'b1 && rx_dv == 1'b0, "R9 crs follows idle carrier", {crs, rx_dv}, 2'b10);
    for (int k = 0; k < 6; k++) drive(1'b1, 2'b10, 1'b0);
    for (int k = 0; k < 8; k++) drive(1'b1, 2'b01, 1'b0);
    drive(1'b1, 2'b11, 1'b0);
    for (int k = 0; k < 8; k++) drive(1'b1, 2'b10, 1'b0);
    idle_gap();
    check(cap_n == c0 && dv_cnt == d0, "R8 false carrier", cap_n - c0, 0);
    check(crs == 1'b0, "R9 crs after carrier", crs, 0);

    c0 = cap_n; d0 = dv_cnt;
    for (int k = 0; k < 4; k++) drive(1'b1, 2'b01, 1'b0);
    drive(1'b1, 2'b00, 1'b0);
    for (int k = 0; k < 3; k++) drive(1'b1, 2'b01, 1'b0);
    drive(1'b1, 2'b11, 1'b0);
    for (int k = 0; k < 8; k++) drive(1'b1, 2'b11, 1'b0);
    idle_gap();
    check(cap_n == c0 && dv_cnt == d0, "R8 broken preamble", cap_n - c0, 0);

    c0 = cap_n; d0 = dv_cnt;
    for (int k = 0; k < 6; k++) drive(1'b1, 2'b00, 1'b0);
    idle_gap();
    check(cap_n == c0 && dv_cnt == d0, "R2 idle carrier of 00", cap_n - c0, 0);

    send_frame(1'b0, 0, 3, 1'b0, 0, 8'h00);
    send_frame(1'b0, 1, 0, 1'b0, 1, 8'hA7);

    speed_10 = 1'b1; per = 10;
    @(negedge clk);
    for (int k = 0; k < 3; k++) drive(1'b1, 2'b01, 1'b0);
    drive(1'b1, 2'b11, 1'b0);
    drive(1'b1, 2'b10, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check({crs, rx_dv, rx_valid} == 3'b0, "R10 reset mid-frame", {crs, rx_dv, rx_valid}, 0);
    crs_dv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle_gap();
    send_frame(1'b1, 2, 2, 1'b1, 0, 8'h6E);

    finish_up();
  end
endmodule